// File: doc/BRIEF.md
# Flash Write-Engine Status Register

This block holds and reports the 8-bit status word of the write engine that drives a nonvolatile memory array. The command decoder tells it when an operation is launched and what kind it is: block erase, byte program, lock-bit set or lock-bit clear. The timing logic signals completion with a pass or fail result, and software may request a suspend or a resume. The supply-OK flag and the three lock indications (master, block, reset-pin) are looked at only at two moments: when an operation is launched and when it finishes. They are never watched continuously.

Error and abort flags latch when they are raised and stay set across later operations until a clear-status command arrives while the engine is ready. While the engine is busy, the read port shows only the busy indication and zeros everywhere else. An operation that is refused for a lock or a low supply produces a one-cycle abort pulse.

All inputs are sampled on the rising clock edge. Their effect shows on `status`, `ready` and `abort` right after that same edge. The reset is synchronous and active high.

Top module: `fws_status_top`

## Requirements
- R1: After reset, status reads 8'h80 (bit 7 ready, all other bits 0), ready is 1 and abort is 0.
- R2: A launch accepted while idle (not suspended) makes ready 0 after the edge. While ready is 0, status reads 8'h00. Kind encoding on op_kind: 0 erase, 1 program, 2 lock set, 3 lock clear.
- R3: op_done while busy returns ready to 1. A passing result adds no error bit.
- R4: A failed erase or lock-clear sets bit 5.
- R5: A failed program or lock-set sets bit 4.
- R6: A launch with seq_err high sets bits 5 and 4 together, does not start the engine, and gives no abort. It takes priority over the lock and supply checks.
- R7: supply_ok low at launch, or at completion, sets bit 3 plus the kind's error bit (bit 5 for erase or lock-clear, bit 4 for program or lock-set). It pulses abort for one cycle and leaves the engine ready.
- R8: Erase and program are refused by the block lock or the pin lock. Lock-set and lock-clear are refused by the master lock or the pin lock. A refusal sets bit 1 plus the kind's error bit and pulses abort. Lock checks come before the supply check.
- R9: suspend_req during a running erase sets bit 6 and makes ready 1.
- R10: suspend_req during a running program sets bit 2 and makes ready 1. Suspend has no effect on lock-bit operations. op_done in the same cycle wins over suspend.
- R11: resume_req while suspended clears bits 6 and 2 and makes ready 0. Launches and completions are ignored while suspended.
- R12: Bits 5, 4, 3 and 1 stay set across later operations. clear_req zeroes them when ready is 1 and has no effect while busy. A clear and a launch in the same cycle apply the clear first.
- R13: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Launch pulse |
| op_kind | input | 2 | Operation kind for the launch |
| seq_err | input | 1 | Improper command sequence, valid with op_start |
| lock_master | input | 1 | Master lock indication |
| lock_block | input | 1 | Target block lock indication |
| lock_pin | input | 1 | Reset-pin lock indication |
| supply_ok | input | 1 | Sampled program supply level is adequate |
| op_done | input | 1 | Completion pulse |
| op_fail | input | 1 | Completion result, 1 = failure |
| suspend_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| clear_req | input | 1 | Clear-status command |
| status | output | 8 | Status word |
| ready | output | 1 | 1 = ready, 0 = busy |
| abort | output | 1 | One-cycle pulse on an aborted operation |

## Verification
The block has no size parameters: the word width and the bit positions are package constants, so the bench builds the one fixed configuration. Directed sequences drive every kind through pass, fail, seq-error, each lock source, and low supply at launch and at completion. Other sequences suspend and resume an erase and a program, and try to suspend a lock operation. A long seeded random run mixes all inputs in the same cycles. It therefore reaches the priority cases: clear together with launch, completion together with suspend, and launches while suspended.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int STAT_W = 8;
  localparam int KIND_W = 2;
  localparam int B_READY = 7;
  localparam int B_ESUSP = 6;
  localparam int B_ERRE  = 5;
  localparam int B_ERRP  = 4;
  localparam int B_LOWV  = 3;
  localparam int B_PSUSP = 2;
  localparam int B_PROT  = 1;

  typedef enum logic [KIND_W-1:0] {
    K_ERASE = 2'd0,
    K_PROG  = 2'd1,
    K_LSET  = 2'd2,
    K_LCLR  = 2'd3
  } fws_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_HOLD = 2'd2
  } fws_state_e;

  typedef struct packed {
    logic erre;
    logic errp;
    logic lowv;
    logic prot;
  } fws_err_t;

  function automatic logic is_cfg(fws_kind_e k);
    return (k == K_LSET) || (k == K_LCLR);
  endfunction

  function automatic logic erase_class(fws_kind_e k);
    return (k == K_ERASE) || (k == K_LCLR);
  endfunction

  function automatic fws_err_t class_bit(fws_kind_e k);
    fws_err_t e;
    e = '0;
    if (erase_class(k)) e.erre = 1'b1;
    else                e.errp = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/fws_gate.sv
module fws_gate
  import fws_pkg::*;
(
  input  logic      admit,
  input  fws_kind_e kind,
  input  logic      seq_err,
  input  logic      lock_master,
  input  logic      lock_block,
  input  logic      lock_pin,
  input  logic      supply_ok,
  output logic      go,
  output fws_err_t  err,
  output logic      abort
);
  logic blocked;

  always_comb begin
    blocked = is_cfg(kind) ? (lock_master | lock_pin) : (lock_block | lock_pin);
    go    = 1'b0;
    err   = '0;
    abort = 1'b0;
    if (admit) begin
      if (seq_err) begin
        err.erre = 1'b1;
        err.errp = 1'b1;
      end else if (blocked) begin
        err      = class_bit(kind);
        err.prot = 1'b1;
        abort    = 1'b1;
      end else if (!supply_ok) begin
        err      = class_bit(kind);
        err.lowv = 1'b1;
        abort    = 1'b1;
      end else begin
        go = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fws_seq.sv
module fws_seq
  import fws_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go,
  input  fws_kind_e go_kind,
  input  logic      done,
  input  logic      suspend_req,
  input  logic      resume_req,
  output logic      idle,
  output logic      run,
  output logic      hold_erase,
  output logic      hold_prog,
  output fws_kind_e cur_kind,
  output logic      fin
);
  fws_state_e st_q, st_d;
  fws_kind_e  kind_q, kind_d;
  logic       susp_ok;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    fin     = 1'b0;
    susp_ok = (kind_q == K_ERASE) || (kind_q == K_PROG);
    unique case (st_q)
      S_IDLE: if (go) begin
        st_d   = S_RUN;
        kind_d = go_kind;
      end
      S_RUN: begin
        if (done) begin
          st_d = S_IDLE;
          fin  = 1'b1;
        end else if (suspend_req && susp_ok) begin
          st_d = S_HOLD;
        end
      end
      S_HOLD: if (resume_req) st_d = S_RUN;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      kind_q <= K_ERASE;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end
  end

  assign idle       = (st_q == S_IDLE);
  assign run        = (st_q == S_RUN);
  assign hold_erase = (st_q == S_HOLD) && (kind_q == K_ERASE);
  assign hold_prog  = (st_q == S_HOLD) && (kind_q == K_PROG);
  assign cur_kind   = kind_q;

  assert_resume_runs_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HOLD && resume_req) |=> (st_q == S_RUN));

  assert_cfg_no_suspend_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RUN && is_cfg(kind_q) && !done) |=> (st_q == S_RUN));

  assert_hold_from_run_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HOLD) |-> ($past(st_q) == S_RUN || $past(st_q) == S_HOLD));
endmodule

// File: rtl/fws_flags.sv
module fws_flags
  import fws_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr_en,
  input  logic     running,
  input  logic     fin,
  input  fws_err_t set_start,
  input  fws_err_t set_fin,
  output fws_err_t flags
);
  fws_err_t flags_q, base;

  always_comb begin
    base = clr_en ? '0 : flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= base | set_start | set_fin;
  end

  assign flags = flags_q;

  assert_sticky_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (running && !fin) |=> $stable(flags_q));

  assert_clear_only_ready_R12: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0 && running) |=> (flags_q != '0));
endmodule

// File: rtl/fws_status_top.sv
module fws_status_top
  import fws_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [KIND_W-1:0] op_kind,
  input  logic              seq_err,
  input  logic              lock_master,
  input  logic              lock_block,
  input  logic              lock_pin,
  input  logic              supply_ok,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clear_req,
  output logic [STAT_W-1:0] status,
  output logic              ready,
  output logic              abort
);
  fws_kind_e kind_in, cur_kind;
  logic      idle, run, hold_e, hold_p, fin;
  logic      go, start_abort, fin_abort, abort_q;
  fws_err_t  start_err, fin_err, flags;

  assign kind_in = fws_kind_e'(op_kind);

  fws_gate u_gate (
    .admit(op_start && idle), .kind(kind_in), .seq_err(seq_err),
    .lock_master(lock_master), .lock_block(lock_block), .lock_pin(lock_pin),
    .supply_ok(supply_ok), .go(go), .err(start_err), .abort(start_abort)
  );

  fws_seq u_seq (
    .clk(clk), .rst(rst), .go(go), .go_kind(kind_in), .done(op_done),
    .suspend_req(suspend_req), .resume_req(resume_req), .idle(idle), .run(run),
    .hold_erase(hold_e), .hold_prog(hold_p), .cur_kind(cur_kind), .fin(fin)
  );

  always_comb begin
    fin_err   = '0;
    fin_abort = 1'b0;
    if (fin) begin
      if (!supply_ok) begin
        fin_err      = class_bit(cur_kind);
        fin_err.lowv = 1'b1;
        fin_abort    = 1'b1;
      end else if (op_fail) begin
        fin_err = class_bit(cur_kind);
      end
    end
  end

  fws_flags u_flags (
    .clk(clk), .rst(rst), .clr_en(clear_req && !run), .running(run), .fin(fin),
    .set_start(start_err), .set_fin(fin_err), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) abort_q <= 1'b0;
    else     abort_q <= start_abort | fin_abort;
  end

  always_comb begin
    status = '0;
    if (!run) begin
      status[B_READY] = 1'b1;
      status[B_ESUSP] = hold_e;
      status[B_ERRE]  = flags.erre;
      status[B_ERRP]  = flags.errp;
      status[B_LOWV]  = flags.lowv;
      status[B_PSUSP] = hold_p;
      status[B_PROT]  = flags.prot;
    end
  end

  assign ready = !run;
  assign abort = abort_q;

  assert_abort_when_ready_R7: assert property (@(posedge clk) disable iff (rst)
    abort |-> ready);

  assert_busy_from_request_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(op_start || resume_req));

  assert_single_suspend_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[B_ESUSP], status[B_PSUSP]}));
endmodule

// File: tb/sim_fws_status_top.sv
module sim_fws_status_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_start, seq_err, lock_master, lock_block, lock_pin, supply_ok;
  logic [1:0] op_kind;
  logic       op_done, op_fail, suspend_req, resume_req, clear_req;
  logic [7:0] status;
  logic       ready, abort;

  int n_chk = 0;
  int n_bad = 0;

  // model state: 0 idle, 1 run, 2 hold
  int         m_st;
  logic [1:0] m_kind;
  logic       m_e5, m_e4, m_v3, m_p1, m_ab;

  always #(CLK_PERIOD/2) clk = ~clk;

  fws_status_top u0 (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind), .seq_err(seq_err),
    .lock_master(lock_master), .lock_block(lock_block), .lock_pin(lock_pin),
    .supply_ok(supply_ok), .op_done(op_done), .op_fail(op_fail),
    .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
    .status(status), .ready(ready), .abort(abort)
  );

  function automatic logic [7:0] exp_status();
    if (m_st == 1) return 8'h00;
    return {1'b1, (m_st == 2 && m_kind == 2'd0), m_e5, m_e4, m_v3,
            (m_st == 2 && m_kind == 2'd1), m_p1, 1'b0};
  endfunction

  task automatic errbit(input logic [1:0] k);
    if (k == 2'd0 || k == 2'd3) m_e5 = 1'b1;
    else                        m_e4 = 1'b1;
  endtask

  task automatic model_step();
    logic blk;
    m_ab = 1'b0;
    if (m_st == 1) begin
      if (op_done) begin
        m_st = 0;
        if (!supply_ok) begin m_v3 = 1'b1; errbit(m_kind); m_ab = 1'b1; end
        else if (op_fail) errbit(m_kind);
      end else if (suspend_req && (m_kind == 2'd0 || m_kind == 2'd1)) m_st = 2;
    end else if (m_st == 2) begin
      if (clear_req) begin m_e5 = 0; m_e4 = 0; m_v3 = 0; m_p1 = 0; end
      if (resume_req) m_st = 1;
    end else begin
      if (clear_req) begin m_e5 = 0; m_e4 = 0; m_v3 = 0; m_p1 = 0; end
      if (op_start) begin
        blk = op_kind[1] ? (lock_master | lock_pin) : (lock_block | lock_pin);
        if (seq_err) begin m_e5 = 1'b1; m_e4 = 1'b1; end
        else if (blk) begin m_p1 = 1'b1; errbit(op_kind); m_ab = 1'b1; end
        else if (!supply_ok) begin m_v3 = 1'b1; errbit(op_kind); m_ab = 1'b1; end
        else begin m_st = 1; m_kind = op_kind; end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    op_start = 0; op_kind = 0; seq_err = 0; lock_master = 0; lock_block = 0;
    lock_pin = 0; supply_ok = 1; op_done = 0; op_fail = 0; suspend_req = 0;
    resume_req = 0; clear_req = 0;
  endtask

  // inputs already set; step the model, clock once, compare with the model
  task automatic cyc();
    model_step();
    @(negedge clk);
    chk("model status", status, exp_status());
    chk("model ready", {7'd0, ready}, {7'd0, (m_st != 1)});
    chk("model abort", {7'd0, abort}, {7'd0, m_ab});
    chk("R13 bit0", {7'd0, status[0]}, 8'd0);
    quiet();
  endtask

  task automatic launch(input logic [1:0] k, input logic sq, input logic lm,
                        input logic lb, input logic lp, input logic sup);
    op_start = 1; op_kind = k; seq_err = sq; lock_master = lm;
    lock_block = lb; lock_pin = lp; supply_ok = sup;
    cyc();
  endtask

  task automatic finish(input logic fl, input logic sup);
    op_done = 1; op_fail = fl; supply_ok = sup;
    cyc();
  endtask

  task automatic clr();     clear_req = 1;   cyc(); endtask
  task automatic susp();    suspend_req = 1; cyc(); endtask
  task automatic resume();  resume_req = 1;  cyc(); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    quiet();
    rst = 1;
    m_st = 0; m_kind = 0; m_e5 = 0; m_e4 = 0; m_v3 = 0; m_p1 = 0; m_ab = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset ready", {7'd0, ready}, 8'd1);
    chk("R1 reset abort", {7'd0, abort}, 8'd0);

    launch(2'd0, 0, 0, 0, 0, 1); chk("R2 busy reads zero", status, 8'h00);
    chk("R2 ready low", {7'd0, ready}, 8'd0);
    finish(0, 1);                chk("R3 pass returns ready", status, 8'h80);

    launch(2'd1, 0, 0, 0, 0, 1); finish(1, 1);
    chk("R5 program fail", status, 8'h90);
    clr();                       chk("R12 clear", status, 8'h80);

    launch(2'd3, 0, 0, 0, 0, 1); finish(1, 1);
    chk("R4 lock-clear fail", status, 8'hA0);
    clr();
    launch(2'd2, 0, 0, 0, 0, 1); finish(1, 1);
    chk("R5 lock-set fail", status, 8'h90);
    clr();
    launch(2'd0, 0, 0, 0, 0, 1); finish(1, 1);
    chk("R4 erase fail", status, 8'hA0);
    clr();

    launch(2'd1, 1, 1, 1, 1, 0);
    chk("R6 sequence error", status, 8'hB0);
    chk("R6 no abort", {7'd0, abort}, 8'd0);
    clr();

    launch(2'd0, 0, 0, 1, 0, 0);
    chk("R8 block lock erase", status, 8'hA2);
    chk("R8 abort", {7'd0, abort}, 8'd1);
    clr();
    launch(2'd2, 0, 0, 1, 0, 1);
    chk("R8 block lock ignored for lock-set", status, 8'h00);
    finish(0, 1);
    launch(2'd2, 0, 1, 0, 0, 1);
    chk("R8 master lock", status, 8'h92);
    clr();
    launch(2'd1, 0, 0, 0, 1, 1);
    chk("R8 pin lock", status, 8'h92);
    clr();

    launch(2'd1, 0, 0, 0, 0, 0);
    chk("R7 low supply at launch", status, 8'h98);
    chk("R7 abort", {7'd0, abort}, 8'd1);
    clr();
    launch(2'd0, 0, 0, 0, 0, 1); finish(0, 0);
    chk("R7 low supply at completion", status, 8'hA8);
    chk("R7 abort at completion", {7'd0, abort}, 8'd1);
    clr();

    launch(2'd0, 0, 0, 0, 0, 1); susp();
    chk("R9 erase suspended", status, 8'hC0);
    launch(2'd1, 0, 0, 0, 0, 1);
    chk("R11 launch ignored while suspended", status, 8'hC0);
    resume();                    chk("R11 resume", status, 8'h00);
    finish(0, 1);                chk("R3 done after resume", status, 8'h80);

    launch(2'd1, 0, 0, 0, 0, 1); susp();
    chk("R10 program suspended", status, 8'h84);
    resume(); finish(1, 1);      chk("R5 fail after resume", status, 8'h90);

    launch(2'd0, 0, 0, 0, 0, 1); clr();
    chk("R12 clear while busy", status, 8'h00);
    finish(0, 1);                chk("R12 sticky kept", status, 8'h90);
    clr();

    launch(2'd2, 0, 0, 0, 0, 1); susp();
    chk("R10 lock op not suspended", status, 8'h00);
    op_done = 1; suspend_req = 1; cyc();
    chk("R10 done wins over suspend", status, 8'h80);

    for (int i = 0; i < 4000; i++) begin
      op_start    = ($urandom % 5) == 0;
      op_kind     = 2'($urandom % 4);
      seq_err     = ($urandom % 10) == 0;
      lock_master = ($urandom % 8) == 0;
      lock_block  = ($urandom % 8) == 0;
      lock_pin    = ($urandom % 12) == 0;
      supply_ok   = ($urandom % 10) != 0;
      op_done     = ($urandom % 6) == 0;
      op_fail     = ($urandom % 3) == 0;
      suspend_req = ($urandom % 8) == 0;
      resume_req  = ($urandom % 5) == 0;
      clear_req   = ($urandom % 9) == 0;
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule